// File: doc/BRIEF.md
# Reciprocal Exponent Estimator

This unit produces a coarse reciprocal estimate from the exponent of a floating-point operand. A 2-bit format select picks half, single or double precision. The result keeps the operand's sign and clears its fraction. Its exponent is the bit-inverted input exponent. An input whose exponent field is zero maps to the largest finite exponent instead. Not-a-number inputs bypass the exponent transform: they are quieted, passed through, or replaced by the default NaN, according to a control bit.

Two further outputs report events. One reports an invalid operation, raised by a signaling NaN. The other reports an input denormal that was flushed to zero. The operand and result ports are 64 bits wide. Narrower formats sit in the low bits, and the unused upper result bits are driven to zero.

A parameter selects the output variant. The default registers the result behind a valid strobe, which gives one cycle of latency. The other variant is purely combinational, so a downstream stage can absorb the logic into its own cycle.

Top module: `recpx_unit`

## Requirements
- R1: `fmt_sel` encodes 0 = half (operand bits 15:0), 1 = single (bits 31:0), 2 = double (bits 63:0). Operand bits above the selected width are ignored, and result bits above it are zero. Code 3 is reserved and yields a zero result with both flags low.
- R2: For a non-NaN operand whose exponent field is non-zero, the result has the operand sign, a zero fraction and an exponent equal to the bitwise complement of the input exponent. An infinity therefore gives a zero of the same sign.
- R3: For a non-NaN operand whose exponent field is zero (a zero or a denormal), the result exponent is the all-ones value minus one: 0x1E, 0xFE or 0x7FE. The sign is kept and the fraction is zero.
- R4: A signaling NaN has an all-ones exponent, a non-zero fraction and a clear top fraction bit. With `dn_mode` low, it produces the operand with its top fraction bit set, and raises `invalid_flag`.
- R5: A quiet NaN (top fraction bit set) with `dn_mode` low is returned unchanged, and both flags stay low.
- R6: With `dn_mode` high, any NaN produces the positive default NaN: 0x7E00, 0x7FC00000 or 0x7FF8000000000000. A signaling NaN still raises `invalid_flag`, and a quiet NaN does not.
- R7: With `flush_mode` high, a denormal operand raises `denorm_flag` and gives the R3 result. `denorm_flag` stays low for a denormal when `flush_mode` is low, and for a true zero.
- R8: In the registered variant (OUT_REG=1), result and flags appear one cycle after the cycle `in_valid` is high. `out_valid` is `in_valid` delayed by one cycle.
- R9: In the registered variant, result and flags hold their values in every cycle after `in_valid` is low.
- R10: After reset, `out_valid`, `result`, `invalid_flag` and `denorm_flag` are all zero.
- R11: In the combinational variant (OUT_REG=0), the outputs follow the inputs in the same cycle, with `out_valid` equal to `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| fmt_sel | input | 2 | Format select (0 half, 1 single, 2 double, 3 reserved) |
| operand | input | 64 | Input value, narrower formats in the low bits |
| dn_mode | input | 1 | Return the default NaN for any NaN input |
| flush_mode | input | 1 | Flush denormal inputs to a signed zero |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Reciprocal exponent estimate |
| invalid_flag | output | 1 | Invalid operation (signaling NaN input) |
| denorm_flag | output | 1 | Input denormal was flushed |

## Verification
The bench builds the block twice from the same stimulus. One copy uses OUT_REG=1 and exposes the one-cycle latency, the valid pipeline and the hold-while-idle behaviour. The other uses OUT_REG=0, so the same expected values are checked in the cycle the operand is applied. The three lane widths are fixed by the formats, so every format code runs in both builds. This covers zero, denormal, infinity and both NaN kinds with each control bit.

// File: rtl/recpx_pkg.sv
package recpx_pkg;

   localparam int DATA_W  = 64;
   localparam int N_LANES = 3;

   typedef enum logic [1:0] {
      FMT_HALF   = 2'd0,
      FMT_SINGLE = 2'd1,
      FMT_DOUBLE = 2'd2,
      FMT_RSVD   = 2'd3
   } recpx_fmt_e;

   typedef struct packed {
      logic [DATA_W-1:0] value;
      logic              inv;
      logic              den;
   } recpx_out_t;

   // exponent width of lane i (0 half, 1 single, 2 double)
   function automatic int lane_exp_w(input int i);
      case (i)
         0:       return 5;
         1:       return 8;
         default: return 11;
      endcase
   endfunction

   // fraction width of lane i
   function automatic int lane_frac_w(input int i);
      case (i)
         0:       return 10;
         1:       return 23;
         default: return 52;
      endcase
   endfunction

endpackage

// File: rtl/recpx_lane.sv
module recpx_lane #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [1+EXP_W+FRAC_W-1:0] x,
   input  logic                      dn,
   input  logic                      fz,
   output logic [1+EXP_W+FRAC_W-1:0] y,
   output logic                      inv,
   output logic                      den
);
   localparam int W = 1 + EXP_W + FRAC_W;
   localparam logic [EXP_W-1:0]  EXP_ONES = {EXP_W{1'b1}};
   localparam logic [EXP_W-1:0]  EXP_MAXF = EXP_ONES - 1'b1;
   localparam logic [FRAC_W-1:0] QBIT     = {1'b1, {(FRAC_W-1){1'b0}}};
   localparam logic [FRAC_W-1:0] FZERO    = {FRAC_W{1'b0}};

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_cfg
      $error("recpx_lane: field widths too small");
   end

   logic              sgn;
   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] fr;
   logic              is_nan;
   logic              is_snan;
   logic              is_sub;

   assign sgn     = x[W-1];
   assign ex      = x[W-2:FRAC_W];
   assign fr      = x[FRAC_W-1:0];
   assign is_nan  = (ex == EXP_ONES) && (fr != FZERO);
   assign is_snan = is_nan && !fr[FRAC_W-1];
   assign is_sub  = (ex == '0) && (fr != FZERO);

   always_comb begin
      y   = '0;
      inv = 1'b0;
      den = 1'b0;
      if (is_nan) begin
         inv = is_snan;
         if (dn) y = {1'b0, EXP_ONES, QBIT};
         else    y = {sgn, ex, fr | QBIT};
      end else if (ex == '0) begin
         den = fz && is_sub;
         y   = {sgn, EXP_MAXF, FZERO};
      end else begin
         y   = {sgn, ~ex, FZERO};
      end
   end
endmodule

// File: rtl/recpx_outstage.sv
module recpx_outstage
   import recpx_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  recpx_out_t d,
   output logic       vld,
   output recpx_out_t q
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld <= 1'b0;
            q   <= '0;
         end else begin
            vld <= in_valid;
            if (in_valid) q <= d;
         end
      end
   end else begin : g_comb
      assign vld = in_valid;
      assign q   = d;
   end
endmodule

// File: rtl/recpx_unit.sv
module recpx_unit
   import recpx_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        fmt_sel,
   input  logic [DATA_W-1:0] operand,
   input  logic              dn_mode,
   input  logic              flush_mode,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              invalid_flag,
   output logic              denorm_flag
);
   logic [DATA_W-1:0] lane_val [N_LANES];
   logic              lane_inv [N_LANES];
   logic              lane_den [N_LANES];

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int EW = lane_exp_w(g);
      localparam int FW = lane_frac_w(g);
      localparam int LW = 1 + EW + FW;

      if (LW > DATA_W) begin : g_too_wide
         $error("recpx_unit: lane wider than data path");
      end

      logic [LW-1:0] y;

      recpx_lane #(.EXP_W(EW), .FRAC_W(FW)) u_lane (
         .x   (operand[LW-1:0]),
         .dn  (dn_mode),
         .fz  (flush_mode),
         .y   (y),
         .inv (lane_inv[g]),
         .den (lane_den[g])
      );

      if (LW == DATA_W) begin : g_full
         assign lane_val[g] = y;
      end else begin : g_ext
         assign lane_val[g] = {{(DATA_W-LW){1'b0}}, y};
      end
   end

   recpx_out_t sel;

   always_comb begin
      sel = '0;
      case (recpx_fmt_e'(fmt_sel))
         FMT_HALF:   sel = '{value: lane_val[0], inv: lane_inv[0], den: lane_den[0]};
         FMT_SINGLE: sel = '{value: lane_val[1], inv: lane_inv[1], den: lane_den[1]};
         FMT_DOUBLE: sel = '{value: lane_val[2], inv: lane_inv[2], den: lane_den[2]};
         default:    sel = '0;
      endcase
   end

   recpx_out_t q;

   recpx_outstage #(.OUT_REG(OUT_REG)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .d        (sel),
      .vld      (out_valid),
      .q        (q)
   );

   assign result       = q.value;
   assign invalid_flag = q.inv;
   assign denorm_flag  = q.den;
endmodule

// File: rtl/recpx_unit_chk.sv
module recpx_unit_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [1:0]  fmt_sel,
   input logic [63:0] operand,
   input logic        dn_mode,
   input logic        flush_mode,
   input logic        out_valid,
   input logic [63:0] result,
   input logic        invalid_flag,
   input logic        denorm_flag
);
   if (OUT_REG) begin : g_reg_props
      p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(result) && $stable(invalid_flag) && $stable(denorm_flag)));
      p_half_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && fmt_sel == 2'd0) |=> (result[63:16] == 48'd0));
      p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && fmt_sel == 2'd3) |=> (result == 64'd0 && !invalid_flag && !denorm_flag));
      p_default_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && dn_mode && fmt_sel == 2'd1 && operand[30:23] == 8'hFF && operand[22:0] != 23'd0)
         |=> (result == 64'h7FC0_0000));
      p_no_flush_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !flush_mode) |=> !denorm_flag);
      p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> !(invalid_flag && denorm_flag));
   end else begin : g_comb_props
      p_comb_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
      p_comb_no_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !flush_mode) |-> !denorm_flag);
      p_comb_rsvd_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && fmt_sel == 2'd3) |-> (result == 64'd0));
      p_comb_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(invalid_flag && denorm_flag));
   end
endmodule

bind recpx_unit recpx_unit_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .fmt_sel      (fmt_sel),
   .operand      (operand),
   .dn_mode      (dn_mode),
   .flush_mode   (flush_mode),
   .out_valid    (out_valid),
   .result       (result),
   .invalid_flag (invalid_flag),
   .denorm_flag  (denorm_flag)
);

// File: tb/recpx_unit_bench.sv
`timescale 1ns/1ps
module recpx_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  fmt_sel = 2'd0;
   logic [63:0] operand = 64'd0;
   logic        dn_mode = 1'b0;
   logic        flush_mode = 1'b0;

   logic        r_vld, c_vld, r_inv, c_inv, r_den, c_den;
   logic [63:0] r_res, c_res;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   recpx_unit #(.OUT_REG(1'b1)) u_recpx_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
      .operand(operand), .dn_mode(dn_mode), .flush_mode(flush_mode),
      .out_valid(r_vld), .result(r_res), .invalid_flag(r_inv), .denorm_flag(r_den));

   recpx_unit #(.OUT_REG(1'b0)) u_recpx_unit_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
      .operand(operand), .dn_mode(dn_mode), .flush_mode(flush_mode),
      .out_valid(c_vld), .result(c_res), .invalid_flag(c_inv), .denorm_flag(c_den));

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // apply one operand, check the combinational copy in-cycle (R11) and the
   // registered copy one cycle later (R8)
   task automatic run_op(input string tag, input logic [1:0] f, input logic [63:0] op,
                         input logic dn, input logic fz, input logic [63:0] e_res,
                         input logic e_inv, input logic e_den);
      @(negedge clk);
      in_valid = 1'b1; fmt_sel = f; operand = op; dn_mode = dn; flush_mode = fz;
      #1;
      check(tag, "comb result R11", c_res, e_res);
      check(tag, "comb invalid R11", {63'd0, c_inv}, {63'd0, e_inv});
      check(tag, "comb denorm R11", {63'd0, c_den}, {63'd0, e_den});
      check(tag, "comb valid R11", {63'd0, c_vld}, 64'd1);
      @(posedge clk);
      #1;
      check(tag, "reg result R8", r_res, e_res);
      check(tag, "reg invalid R8", {63'd0, r_inv}, {63'd0, e_inv});
      check(tag, "reg denorm R8", {63'd0, r_den}, {63'd0, e_den});
      check(tag, "reg valid R8", {63'd0, r_vld}, 64'd1);
   endtask

   task automatic t_reset;
      #1;
      check("R10", "out_valid", {63'd0, r_vld}, 64'd0);
      check("R10", "result", r_res, 64'd0);
      check("R10", "flags", {62'd0, r_inv, r_den}, 64'd0);
   endtask

   task automatic t_formats;
      run_op("R1", 2'd0, 64'hDEAD_BEEF_1234_3C00, 0, 0, 64'h4000, 0, 0);
      run_op("R1", 2'd1, 64'hFFFF_FFFF_3F80_0000, 0, 0, 64'h4000_0000, 0, 0);
      run_op("R1", 2'd3, 64'h7FF0_0000_0000_0001, 1, 1, 64'd0, 0, 0);
   endtask

   task automatic t_normal;
      run_op("R2", 2'd0, 64'hBC55, 0, 0, 64'hC000, 0, 0);
      run_op("R2", 2'd1, 64'hC120_0000, 0, 0, 64'hBE80_0000, 0, 0);
      run_op("R2", 2'd2, 64'h3FF0_0000_0000_0000, 0, 0, 64'h4000_0000_0000_0000, 0, 0);
      run_op("R2", 2'd0, 64'hFC00, 0, 0, 64'h8000, 0, 0);
      run_op("R2", 2'd2, 64'h7FF0_0000_0000_0000, 0, 0, 64'd0, 0, 0);
   endtask

   task automatic t_zero_exp;
      run_op("R3", 2'd0, 64'h0000, 0, 0, 64'h7800, 0, 0);
      run_op("R3", 2'd0, 64'h8000, 0, 0, 64'hF800, 0, 0);
      run_op("R3", 2'd1, 64'h0000_0000, 0, 0, 64'h7F00_0000, 0, 0);
      run_op("R3", 2'd2, 64'h800F_0000_0000_0000, 0, 0, 64'hFFE0_0000_0000_0000, 0, 0);
   endtask

   task automatic t_nan;
      run_op("R4", 2'd0, 64'h7C01, 0, 0, 64'h7E01, 1, 0);
      run_op("R4", 2'd1, 64'h7F80_0001, 0, 0, 64'h7FC0_0001, 1, 0);
      run_op("R4", 2'd2, 64'hFFF0_0000_0000_0001, 0, 0, 64'hFFF8_0000_0000_0001, 1, 0);
      run_op("R5", 2'd0, 64'hFE12, 0, 0, 64'hFE12, 0, 0);
      run_op("R5", 2'd1, 64'hFFC0_1234, 0, 1, 64'hFFC0_1234, 0, 0);
      run_op("R6", 2'd0, 64'h7C01, 1, 0, 64'h7E00, 1, 0);
      run_op("R6", 2'd0, 64'hFE12, 1, 0, 64'h7E00, 0, 0);
      run_op("R6", 2'd1, 64'hFF80_0001, 1, 0, 64'h7FC0_0000, 1, 0);
      run_op("R6", 2'd2, 64'hFFF8_0000_0000_0005, 1, 0, 64'h7FF8_0000_0000_0000, 0, 0);
   endtask

   task automatic t_flush;
      run_op("R7", 2'd0, 64'h0001, 0, 0, 64'h7800, 0, 0);
      run_op("R7", 2'd0, 64'h0001, 0, 1, 64'h7800, 0, 1);
      run_op("R7", 2'd1, 64'h8000_0005, 0, 1, 64'hFF00_0000, 0, 1);
      run_op("R7", 2'd2, 64'h0000_0000_0000_0000, 0, 1, 64'h7FE0_0000_0000_0000, 0, 0);
   endtask

   task automatic t_hold;
      run_op("R9", 2'd1, 64'h7F80_0001, 0, 0, 64'h7FC0_0001, 1, 0);
      @(negedge clk);
      in_valid = 1'b0; fmt_sel = 2'd0; operand = 64'h0001; flush_mode = 1'b1;
      @(posedge clk); #1;
      check("R8", "valid drops", {63'd0, r_vld}, 64'd0);
      @(posedge clk); #1;
      check("R9", "held result", r_res, 64'h7FC0_0001);
      check("R9", "held flags", {62'd0, r_inv, r_den}, 64'h2);
      check("R11", "comb valid low", {63'd0, c_vld}, 64'd0);
   endtask

   initial begin
      t_reset();
      #12;
      rst_n = 1'b1;
      t_formats();
      t_normal();
      t_zero_exp();
      t_nan();
      t_flush();
      t_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule